// File: doc/BRIEF.md
# Multi-Channel Code Register I2C Target

This block is an I2C target that holds one 10-bit output code for each of a set of channels. The channel count is a parameter and is normally 10 or 12. It sits behind a pair of open-drain bus lines. The target never stretches the clock, so SCL is an input only. The target pulls SDA low through a single output that the pad logic turns into an open-drain driver. A strap input supplies the least significant bit of the 7-bit bus address. The upper six address bits are fixed at `111010`, so the block answers at 0x74 or at 0x75. The stored codes are presented continuously on a flat parallel output, and downstream conversion logic consumes them from there.

A mode-select input picks one of two access schemes. With the input high, a transfer is a burst. Written data fills the channels in order from channel 0, and a read returns the channels in that same order. With the input low, the first written byte is a channel pointer, and exactly two code bytes then apply to that channel. In this mode a read is a pointer write, then a repeated START with the read bit, then two bytes. Each code travels as two bytes. The first byte carries code bits 9..8 in its bits 1..0, and the second byte carries code bits 7..0.

Top module: `gamma_code_i2c_target`

## Requirements
- R1: The target acknowledges an address byte only when its upper seven bits equal `111010` followed by the strap input. For any other address it leaves SDA released for the rest of that transfer, including every later acknowledge slot, so the codes are unchanged.
- R2: Bits are sampled MSB first on SCL rising edges. For each byte it accepts, the target holds SDA low during the ninth clock. It changes its SDA drive only while SCL is low.
- R3: In burst mode (mode input high), data bytes 2k and 2k+1 after a write address set channel k. Bits 1..0 of the first byte become code bits 9..8, and its bits 7..2 are ignored. The second byte becomes code bits 7..0.
- R4: A burst-mode read returns two bytes per channel in channel order from channel 0. The first byte of each pair is six zero bits followed by code bits 9..8, and the second byte is code bits 7..0.
- R5: In register mode (mode input low), the first written data byte is a pointer whose bits 3..0 select the channel and whose bits 7..4 are ignored. The next two bytes set that channel's code with the same packing as R3.
- R6: A register-mode read (pointer write, repeated START, read address) returns the pointed channel's code as two bytes packed as in R4.
- R7: A channel's code changes only when its second code byte is received, and at most one channel changes per cycle. A transfer that ends after the first code byte leaves the code unchanged.
- R8: A pointer at or above the channel count is acknowledged but writes nothing, and reads through it return 0x00.
- R9: Write bytes beyond the last channel in burst mode, or beyond the two code bytes in register mode, are acknowledged and discarded.
- R10: When the master does not acknowledge a byte it read, the target releases SDA and drives nothing until the next START or STOP.
- R11: After reset every code is zero and SDA is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, at least 16 times the bus bit rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull_o | output | 1 | High when the target pulls the data line low |
| strap_a0_i | input | 1 | Address bit 0 strap |
| burst_sel_i | input | 1 | 1 selects burst mode, 0 selects pointer (register) mode |
| codes_o | output | NUM_CH*CODE_W | Stored codes, channel k at bits [k*CODE_W +: CODE_W] |

## Verification
The assertions assume a well-behaved master. SDA moves only while SCL is low, except at START and STOP. Each SCL phase lasts several system clocks, so the two-stage synchronizer never merges two edges. No START or STOP is issued while the target holds SDA low. The bench drives a quarter-bit of eight system clocks and changes SDA only a full quarter-bit after SCL falls, which is after the target's own release or drive has settled. It issues START and STOP only on a released line. The mode input and strap are changed only between transfers.

// File: rtl/gcr_pkg.sv
package gcr_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned PTR_W  = 4;

  // Link-level phases of the bit engine
  typedef enum logic [2:0] {
    LK_IDLE,     // bus free or transfer not ours
    LK_RX,       // shifting in a byte
    LK_RXEND,    // byte complete, waiting for SCL low to decide ACK
    LK_ACK,      // holding SDA low through the acknowledge clock
    LK_TX,       // shifting out a byte
    LK_MACK,     // waiting for master acknowledge sample
    LK_MACKEND,  // master acknowledged, waiting for SCL low
    LK_WAIT      // ignoring the bus until START/STOP
  } link_st_t;

endpackage

// File: rtl/gcr_line_sync.sv
module gcr_line_sync #(
  parameter int unsigned SYNC_N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  logic [SYNC_N-1:0] scl_ff_q, sda_ff_q;
  logic              scl_old_q, sda_old_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff_q  <= '1;
      sda_ff_q  <= '1;
      scl_old_q <= 1'b1;
      sda_old_q <= 1'b1;
    end else begin
      scl_ff_q  <= {scl_ff_q[SYNC_N-2:0], scl_i};
      sda_ff_q  <= {sda_ff_q[SYNC_N-2:0], sda_i};
      scl_old_q <= scl_ff_q[SYNC_N-1];
      sda_old_q <= sda_ff_q[SYNC_N-1];
    end
  end

  assign scl_o      = scl_ff_q[SYNC_N-1];
  assign sda_o      = sda_ff_q[SYNC_N-1];
  assign scl_rise_o = scl_o & ~scl_old_q;
  assign scl_fall_o = ~scl_o & scl_old_q;
  assign start_o    = scl_o & scl_old_q & sda_old_q & ~sda_o;
  assign stop_o     = scl_o & scl_old_q & ~sda_old_q & sda_o;

endmodule

// File: rtl/gcr_link.sv
module gcr_link
  import gcr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              addr_hit_i,
  input  logic              rd_dir_i,
  input  logic [BYTE_W-1:0] tx_byte_i,
  output logic              rx_done_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              rx_addr_o,
  output logic              tx_load_o,
  output logic              sda_pull_o,
  output link_st_t          st_o
);

  link_st_t          st_q, st_d;
  logic [2:0]        cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              pull_q, pull_d;
  logic              addr_q, addr_d;

  // Next state
  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    sh_d      = sh_q;
    pull_d    = pull_q;
    addr_d    = addr_q;
    rx_done_o = 1'b0;
    tx_load_o = 1'b0;
    if (start_i) begin
      st_d   = LK_RX;
      cnt_d  = '0;
      addr_d = 1'b1;
      pull_d = 1'b0;
    end else if (stop_i) begin
      st_d   = LK_IDLE;
      pull_d = 1'b0;
    end else begin
      unique case (st_q)
        LK_RX: if (scl_rise_i) begin
          sh_d  = {sh_q[BYTE_W-2:0], sda_i};
          cnt_d = cnt_q + 3'd1;
          if (cnt_q == 3'd7) begin
            rx_done_o = 1'b1;
            st_d      = LK_RXEND;
          end
        end
        LK_RXEND: if (scl_fall_i) begin
          if (!addr_q || addr_hit_i) begin
            st_d   = LK_ACK;
            pull_d = 1'b1;
          end else begin
            st_d = LK_WAIT;
          end
        end
        LK_ACK, LK_MACKEND: if (scl_fall_i) begin
          cnt_d  = '0;
          pull_d = 1'b0;
          if (st_q == LK_MACKEND || (addr_q && rd_dir_i)) begin
            tx_load_o = 1'b1;
            sh_d      = tx_byte_i;
            pull_d    = ~tx_byte_i[BYTE_W-1];
            st_d      = LK_TX;
          end else begin
            st_d = LK_RX;
          end
          addr_d = 1'b0;
        end
        LK_TX: if (scl_fall_i) begin
          if (cnt_q == 3'd7) begin
            pull_d = 1'b0;
            st_d   = LK_MACK;
          end else begin
            sh_d   = {sh_q[BYTE_W-2:0], 1'b0};
            pull_d = ~sh_q[BYTE_W-2];
            cnt_d  = cnt_q + 3'd1;
          end
        end
        LK_MACK: if (scl_rise_i) begin
          st_d = sda_i ? LK_WAIT : LK_MACKEND;
        end
        default: ;
      endcase
    end
  end

  // Registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= LK_IDLE;
      cnt_q  <= '0;
      sh_q   <= '0;
      pull_q <= 1'b0;
      addr_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      pull_q <= pull_d;
      addr_q <= addr_d;
    end
  end

  assign rx_byte_o  = {sh_q[BYTE_W-2:0], sda_i};
  assign rx_addr_o  = addr_q;
  assign sda_pull_o = pull_q;
  assign st_o       = st_q;

endmodule

// File: rtl/gcr_code_bank.sv
module gcr_code_bank #(
  parameter int unsigned NUM_CH = 12,
  parameter int unsigned CODE_W = 10,
  parameter int unsigned IDX_W  = 5
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [IDX_W-1:0]         wr_idx_i,
  input  logic [CODE_W-1:0]        wr_code_i,
  input  logic [IDX_W-1:0]         rd_idx_i,
  output logic [CODE_W-1:0]        rd_code_o,
  output logic [NUM_CH*CODE_W-1:0] codes_o
);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic [CODE_W-1:0] code_q;
    logic              load;

    assign load = wr_en_i && (wr_idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        code_q <= '0;
      end else if (load) begin
        code_q <= wr_code_i;
      end
    end

    assign codes_o[g*CODE_W +: CODE_W] = code_q;
  end

  // Read port: out-of-range index yields zero
  always_comb begin
    rd_code_o = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (rd_idx_i == IDX_W'(i)) rd_code_o = codes_o[i*CODE_W +: CODE_W];
    end
  end

endmodule

// File: rtl/gamma_code_i2c_target.sv
module gamma_code_i2c_target
  import gcr_pkg::*;
#(
  parameter int unsigned NUM_CH  = 12,
  parameter int unsigned CODE_W  = 10,
  parameter logic [5:0]  ADDR_HI = 6'b111010
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     scl_i,
  input  logic                     sda_i,
  output logic                     sda_pull_o,
  input  logic                     strap_a0_i,
  input  logic                     burst_sel_i,
  output logic [NUM_CH*CODE_W-1:0] codes_o
);

  localparam int unsigned HI_W   = CODE_W - BYTE_W;
  localparam int unsigned SLOT_W = $clog2(2*NUM_CH + 2);
  localparam int unsigned IDX_W  = (SLOT_W > PTR_W) ? SLOT_W : PTR_W;
  localparam logic [SLOT_W-1:0] SLOT_MAX = '1;
  localparam logic [IDX_W-1:0]  CH_LIM   = IDX_W'(NUM_CH);

  // Reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_ns;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= '0;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_ns = rst_pipe_q[1];

  // Line synchronizer
  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;

  gcr_line_sync #(.SYNC_N(2)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ns),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_ev),
    .stop_o     (stop_ev)
  );

  // Transaction state
  logic              hit_q, hit_d;
  logic              rd_q, rd_d;
  logic              burst_q, burst_d;
  logic [PTR_W-1:0]  ptr_q, ptr_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [HI_W-1:0]   stage_q, stage_d;

  logic              rx_done, rx_addr, tx_load;
  logic [BYTE_W-1:0] rx_byte, tx_byte;
  link_st_t          link_st;

  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [CODE_W-1:0] wr_code;
  logic [IDX_W-1:0]  rd_idx, burst_ch, ptr_ch;
  logic [CODE_W-1:0] rd_code;
  logic              rd_ok;

  gcr_link u_link (
    .clk_i      (clk_i),
    .rst_ni     (rst_ns),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .sda_i      (sda_s),
    .start_i    (start_ev),
    .stop_i     (stop_ev),
    .addr_hit_i (hit_q),
    .rd_dir_i   (rd_q),
    .tx_byte_i  (tx_byte),
    .rx_done_o  (rx_done),
    .rx_byte_o  (rx_byte),
    .rx_addr_o  (rx_addr),
    .tx_load_o  (tx_load),
    .sda_pull_o (sda_pull_o),
    .st_o       (link_st)
  );

  gcr_code_bank #(.NUM_CH(NUM_CH), .CODE_W(CODE_W), .IDX_W(IDX_W)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ns),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_code_i (wr_code),
    .rd_idx_i  (rd_idx),
    .rd_code_o (rd_code),
    .codes_o   (codes_o)
  );

  assign burst_ch = IDX_W'(slot_q >> 1);
  assign ptr_ch   = IDX_W'(ptr_q);

  // Next state of the transaction layer
  always_comb begin
    hit_d   = hit_q;
    rd_d    = rd_q;
    burst_d = burst_q;
    ptr_d   = ptr_q;
    slot_d  = slot_q;
    stage_d = stage_q;
    wr_en   = 1'b0;
    wr_idx  = '0;
    wr_code = '0;
    if (rx_done) begin
      if (rx_addr) begin
        hit_d   = (rx_byte[BYTE_W-1:1] == {ADDR_HI, strap_a0_i});
        rd_d    = rx_byte[0];
        burst_d = burst_sel_i;
        slot_d  = '0;
      end else if (hit_q && !rd_q) begin
        if (slot_q != SLOT_MAX) slot_d = slot_q + 1'b1;
        if (burst_q) begin
          if (!slot_q[0]) begin
            stage_d = rx_byte[HI_W-1:0];
          end else if (burst_ch < CH_LIM) begin
            wr_en   = 1'b1;
            wr_idx  = burst_ch;
            wr_code = {stage_q, rx_byte};
          end
        end else begin
          if (slot_q == SLOT_W'(0)) begin
            ptr_d = rx_byte[PTR_W-1:0];
          end else if (slot_q == SLOT_W'(1)) begin
            stage_d = rx_byte[HI_W-1:0];
          end else if (slot_q == SLOT_W'(2) && ptr_ch < CH_LIM) begin
            wr_en   = 1'b1;
            wr_idx  = ptr_ch;
            wr_code = {stage_q, rx_byte};
          end
        end
      end
    end
    if (tx_load && slot_q != SLOT_MAX) slot_d = slot_q + 1'b1;
  end

  // Read data selection
  always_comb begin
    rd_idx = burst_q ? burst_ch : ptr_ch;
    rd_ok  = burst_q ? (burst_ch < CH_LIM)
                     : (slot_q < SLOT_W'(2) && ptr_ch < CH_LIM);
    if (!rd_ok)         tx_byte = '0;
    else if (slot_q[0]) tx_byte = rd_code[BYTE_W-1:0];
    else                tx_byte = BYTE_W'(rd_code[CODE_W-1:BYTE_W]);
  end

  always_ff @(posedge clk_i or negedge rst_ns) begin
    if (!rst_ns) begin
      hit_q   <= 1'b0;
      rd_q    <= 1'b0;
      burst_q <= 1'b0;
      ptr_q   <= '0;
      slot_q  <= '0;
      stage_q <= '0;
    end else begin
      hit_q   <= hit_d;
      rd_q    <= rd_d;
      burst_q <= burst_d;
      ptr_q   <= ptr_d;
      slot_q  <= slot_d;
      stage_q <= stage_d;
    end
  end

endmodule

// File: rtl/gcr_checker.sv
module gcr_checker
  import gcr_pkg::*;
#(
  parameter int unsigned NUM_CH = 12,
  parameter int unsigned CODE_W = 10,
  parameter int unsigned IDX_W  = 5
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     sda_pull_i,
  input logic                     scl_s_i,
  input logic                     start_i,
  input logic                     stop_i,
  input link_st_t                 st_i,
  input logic                     wr_en_i,
  input logic [IDX_W-1:0]         wr_idx_i,
  input logic [NUM_CH*CODE_W-1:0] codes_i
);

  localparam logic [IDX_W-1:0] CH_LIM = IDX_W'(NUM_CH);

  logic [NUM_CH*CODE_W-1:0] prev_q;
  logic [NUM_CH-1:0]        chg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= codes_i;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chg
    assign chg[g] = codes_i[g*CODE_W +: CODE_W] != prev_q[g*CODE_W +: CODE_W];
  end

  // R1 and R10: no drive while the transfer is not ours or was NACKed
  assert_quiet_unaddressed_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == LK_IDLE || st_i == LK_WAIT) |-> !sda_pull_i);

  // R2: drive changes only while synchronized SCL is low
  assert_sda_moves_scl_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(sda_pull_i) && !$past(start_i || stop_i)) |-> !$past(scl_s_i));

  // R7: at most one channel updates, and only after a committed write
  assert_single_update_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(chg));

  assert_update_needs_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|chg) |-> $past(wr_en_i));

  // R8: writes only ever target an existing channel
  assert_write_in_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> (wr_idx_i < CH_LIM));

endmodule

bind gamma_code_i2c_target gcr_checker #(
  .NUM_CH (NUM_CH),
  .CODE_W (CODE_W),
  .IDX_W  (IDX_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ns),
  .sda_pull_i (sda_pull_o),
  .scl_s_i    (scl_s),
  .start_i    (start_ev),
  .stop_i     (stop_ev),
  .st_i       (link_st),
  .wr_en_i    (wr_en),
  .wr_idx_i   (wr_idx),
  .codes_i    (codes_o)
);

// File: tb/gamma_code_i2c_target_tb.sv
`timescale 1ns/1ps
module gamma_code_i2c_target_tb;

  localparam int NCH = 12;
  localparam int CW  = 10;
  localparam int Q   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic strap = 1'b0;
  logic burst = 1'b1;
  logic pull;
  logic sda_line;
  logic [NCH*CW-1:0] codes;

  int tests = 0;
  int failed = 0;
  int model [NCH];

  always #10 clk = ~clk;

  assign sda_line = m_sda & ~pull;

  gamma_code_i2c_target #(.NUM_CH(NCH), .CODE_W(CW)) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .scl_i       (m_scl),
    .sda_i       (sda_line),
    .sda_pull_o  (pull),
    .strap_a0_i  (strap),
    .burst_sel_i (burst),
    .codes_o     (codes)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_codes(input string req);
    for (int c = 0; c < NCH; c++) chk(req, int'(codes[c*CW +: CW]), model[c]);
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq();
  endtask

  task automatic clk_bit(input logic b, output logic s);
    m_sda = b; wq(); m_scl = 1'b1; wq(); s = sda_line; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      b[i] = s;
    end
    clk_bit(~mack, s);
  endtask

  function automatic int pat(input int c, input int seed);
    return (c * seed * 7 + seed * 31 + 5) % 1024;
  endfunction

  // Burst write of all channels plus extra trailing bytes
  task automatic burst_write(input logic [7:0] abyte, input int seed, input int extra,
                             input string req);
    logic ack;
    int v;
    bus_start();
    send_byte(abyte, ack); chk("R1 address ack", int'(ack), 1);
    for (int c = 0; c < NCH; c++) begin
      v = pat(c, seed);
      send_byte(8'((c * 37) & 8'hFC) | 8'(v >> 8), ack); chk(req, int'(ack), 1);
      send_byte(8'(v), ack); chk(req, int'(ack), 1);
      model[c] = v;
    end
    for (int e = 0; e < extra; e++) begin
      send_byte(8'hFF, ack); chk("R9 extra burst byte ack", int'(ack), 1);
    end
    bus_stop();
  endtask

  task automatic reg_write(input logic [7:0] pbyte, input int v, input int extra);
    logic ack;
    bus_start();
    send_byte(8'hE8, ack); chk("R5 address ack", int'(ack), 1);
    send_byte(pbyte, ack); chk("R8 pointer ack", int'(ack), 1);
    send_byte(8'hA8 | 8'(v >> 8), ack); chk("R5 hi ack", int'(ack), 1);
    send_byte(8'(v), ack); chk("R5 lo ack", int'(ack), 1);
    for (int e = 0; e < extra; e++) begin
      send_byte(8'h3C, ack); chk("R9 extra reg byte ack", int'(ack), 1);
    end
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failed++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] b;
    int v;
    for (int c = 0; c < NCH; c++) model[c] = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R11: reset state
    check_codes("R11 reset code");
    chk("R11 sda released", int'(pull), 0);

    // R3: burst write at 0x74
    burst_write(8'hE8, 3, 0, "R3 data ack");
    check_codes("R3 burst write");

    // R4: burst read, all channels
    bus_start();
    send_byte(8'hE9, ack); chk("R1 read address ack", int'(ack), 1);
    for (int k = 0; k < 2*NCH; k++) begin
      recv_byte(k != 2*NCH-1, b);
      if (k % 2 == 0) chk("R4 burst hi byte", int'(b), model[k/2] >> 8);
      else            chk("R4 burst lo byte", int'(b), model[k/2] & 255);
    end
    bus_stop();

    // R1: foreign addresses are ignored
    bus_start();
    send_byte(8'hEA, ack); chk("R1 wrong lsb nack", int'(ack), 0);
    send_byte(8'h00, ack); chk("R1 no data ack", int'(ack), 0);
    send_byte(8'h00, ack); chk("R1 no data ack", int'(ack), 0);
    bus_stop();
    bus_start();
    send_byte(8'hC8, ack); chk("R1 wrong upper nack", int'(ack), 0);
    bus_stop();
    check_codes("R1 codes untouched");

    // R1: strap moves the address to 0x75
    strap = 1'b1;
    burst_write(8'hEA, 5, 0, "R1 strap data ack");
    check_codes("R1 strap write");
    bus_start();
    send_byte(8'hE8, ack); chk("R1 old address nack", int'(ack), 0);
    bus_stop();
    strap = 1'b0;

    // R9: extra burst bytes discarded
    burst_write(8'hE8, 9, 3, "R9 data ack");
    check_codes("R9 burst extras");

    // R7: burst transfer cut after first code byte
    bus_start();
    send_byte(8'hE8, ack);
    send_byte(8'h03, ack); chk("R7 hi ack", int'(ack), 1);
    bus_stop();
    check_codes("R7 burst partial");

    // R5 and R8: register-mode writes over every pointer value
    burst = 1'b0;
    for (int p = 0; p < 16; p++) begin
      v = (p * 149 + 3) % 1024;
      reg_write(8'((p * 5) << 4) | 8'(p), v, 0);
      if (p < NCH) model[p] = v;
      check_codes(p < NCH ? "R5 register write" : "R8 out of range write");
    end

    // R6 and R8: register-mode reads over every pointer value
    for (int p = 0; p < 16; p++) begin
      bus_start();
      send_byte(8'hE8, ack);
      send_byte(8'hF0 | 8'(p), ack);
      bus_start();
      send_byte(8'hE9, ack); chk("R6 read address ack", int'(ack), 1);
      recv_byte(1'b1, b);
      chk(p < NCH ? "R6 hi byte" : "R8 hi byte", int'(b), p < NCH ? model[p] >> 8 : 0);
      recv_byte(1'b0, b);
      chk(p < NCH ? "R6 lo byte" : "R8 lo byte", int'(b), p < NCH ? model[p] & 255 : 0);
      bus_stop();
    end

    // R9: bytes past the code pair in register mode
    reg_write(8'h05, 777, 2);
    model[5] = 777;
    check_codes("R9 register extras");

    // R7: register transfer cut after first code byte
    bus_start();
    send_byte(8'hE8, ack);
    send_byte(8'h02, ack);
    send_byte(8'h03, ack);
    chk("R7 partial no change", int'(codes[2*CW +: CW]), model[2]);
    bus_stop();
    check_codes("R7 register partial");

    // R10: after master NACK the line stays released
    burst = 1'b1;
    bus_start();
    send_byte(8'hE9, ack);
    recv_byte(1'b1, b); chk("R4 first byte", int'(b), model[0] >> 8);
    recv_byte(1'b0, b); chk("R4 second byte", int'(b), model[0] & 255);
    recv_byte(1'b0, b); chk("R10 released after nack", int'(b), 255);
    bus_stop();
    chk("R11 idle release", int'(pull), 0);

    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

endmodule